// File: doc/BRIEF.md
# Programming-Status Read Multiplexer

This block sits on the read path of a byte-wide nonvolatile memory. When the memory is idle, a read returns the stored byte that the array presents for the current address. While an internal programming cycle runs, stored data is not returned. Two status bits take its place so that a host can tell when programming has finished. The top bit returns the inverse of the top bit of the byte that was last written. The bit below it changes value on every new read access.

The write controller supplies the busy flag and the last written byte. The array supplies the read data. The host strobes are active low: a read is in progress while chip select and output enable are low and write enable is high. The block drives an 8-bit data word and a drive-enable for the bidirectional pins. Output timing is modelled as one clock of registered latency.

The busy flag covers any internal timed cycle. This includes the dummy cycle started by a write that protection rejected, so reads during that cycle are polling reads as well.

Top module: `rdpoll_status_rd`

## Requirements
- R1: The drive-enable output goes high one clock after a sample in which chip select is low, output enable is low and write enable is high. In every other strobe combination it is low one clock later, and while it is low the data output reads 0.
- R2: While busy is low and the read strobe is active, the data output equals the array data sampled one clock earlier. It tracks address changes while the strobe is held.
- R3: While busy is high, a read returns bit 7 equal to the inverse of bit 7 of the last written byte, whatever that byte is.
- R4: While busy is high, bit 6 on the first read access of a programming cycle is 0. Each later access in the same cycle returns the opposite value of the previous access.
- R5: The bit-6 value advances only when a new access begins, meaning the strobe goes from inactive to active. Holding the strobe active for many cycles keeps bit 6 stable.
- R6: Once busy falls, all eight bits carry the array data from the next clock. This holds even when the strobe has stayed active across the end of busy.
- R7: A new programming cycle (busy rising after at least one low sample) restarts bit 6 at 0, whatever the parity left by the previous cycle.
- R8: After reset, the drive-enable output is 0 and the data output is 0.
- R9: An access that begins in the same clock that busy rises already returns the busy status, with bit 6 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| busy_i | input | 1 | Programming cycle in progress, from the write controller |
| last_data_i | input | 8 | Byte most recently written |
| arr_data_i | input | 8 | Array read data for the current address |
| data_o | output | 8 | Read data or status word |
| data_oe_o | output | 1 | Drive-enable for the data pins |

## Verification
Two situations are hard to reach from the ports. The first is a read access that starts on the exact clock busy rises. The bench sets busy and the strobe on the same falling edge to produce it. The second is a new programming cycle that begins with the toggle parity left odd by the cycle before. The bench gets there by ending one busy period after an odd number of reads and then starting another. It also holds the strobe across the fall of busy, to show that true data returns without a new access, and it sweeps every last-written byte value during a long run of alternating polls.

// File: rtl/rdpoll_pkg.sv
package rdpoll_pkg;
  parameter int DATA_W   = 8;
  parameter int POLL_BIT = 7;
  parameter int TGL_BIT  = 6;

  typedef struct packed {
    logic act;
    logic start;
  } rd_evt_t;
endpackage

// File: rtl/rdpoll_strobe.sv
module rdpoll_strobe
  import rdpoll_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ce_ni,
  input  logic    oe_ni,
  input  logic    we_ni,
  output rd_evt_t evt_o
);
  logic act, act_q;

  assign act = ~ce_ni & ~oe_ni & we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  // one start per access, not per cycle held
  assign evt_o.act   = act;
  assign evt_o.start = act & ~act_q;
endmodule

// File: rtl/rdpoll_toggle.sv
module rdpoll_toggle
  import rdpoll_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    busy_i,
  input  rd_evt_t evt_i,
  output logic    show_nxt_o
);
  logic busy_q, tgl_q, show_q;
  logic busy_start, base;

  assign busy_start = busy_i & ~busy_q;
  assign base       = busy_start ? 1'b0 : tgl_q;
  assign show_nxt_o = (evt_i.start && busy_i) ? base : show_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tgl_q  <= 1'b0;
      show_q <= 1'b0;
    end else begin
      busy_q <= busy_i;
      show_q <= show_nxt_o;
      if (evt_i.start && busy_i) tgl_q <= ~base;
      else                       tgl_q <= base;
    end
  end
endmodule

// File: rtl/rdpoll_mux.sv
module rdpoll_mux
  import rdpoll_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rd_evt_t      evt_i,
  input  logic         busy_i,
  input  logic         show_i,
  input  logic [W-1:0] last_data_i,
  input  logic [W-1:0] arr_data_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  logic [W-1:0] word, data_q;
  logic         oe_q;

  always_comb begin
    word = arr_data_i;
    if (busy_i) begin
      word[POLL_BIT] = ~last_data_i[POLL_BIT];
      word[TGL_BIT]  = show_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= evt_i.act;
      if (evt_i.act) data_q <= word;
    end
  end

  assign data_oe_o = oe_q;
  assign data_o    = oe_q ? data_q : '0;
endmodule

// File: rtl/rdpoll_status_rd.sv
module rdpoll_status_rd
  import rdpoll_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         oe_ni,
  input  logic         we_ni,
  input  logic         busy_i,
  input  logic [W-1:0] last_data_i,
  input  logic [W-1:0] arr_data_i,
  output logic [W-1:0] data_o,
  output logic         data_oe_o
);
  rd_evt_t evt;
  logic    show_nxt;

  rdpoll_strobe u_strobe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_ni (ce_ni),
    .oe_ni (oe_ni),
    .we_ni (we_ni),
    .evt_o (evt)
  );

  rdpoll_toggle u_toggle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .evt_i     (evt),
    .show_nxt_o(show_nxt)
  );

  rdpoll_mux #(.W(W)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt),
    .busy_i     (busy_i),
    .show_i     (show_nxt),
    .last_data_i(last_data_i),
    .arr_data_i (arr_data_i),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );
endmodule

// File: rtl/rdpoll_status_rd_chk.sv
module rdpoll_status_rd_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ce_ni,
  input logic         oe_ni,
  input logic         we_ni,
  input logic         busy_i,
  input logic [W-1:0] last_data_i,
  input logic [W-1:0] arr_data_i,
  input logic [W-1:0] data_o,
  input logic         data_oe_o
);
  logic rd;
  assign rd = ~ce_ni & ~oe_ni & we_ni;

  // R1
  no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !data_oe_o);

  // R1
  quiet_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  // R2
  idle_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && !busy_i) |=> (data_oe_o && data_o == $past(arr_data_i)));

  // R3
  poll_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy_i) |=> data_o[W-1] == ~$past(last_data_i[W-1]));

  // R5
  held_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && busy_i && $past(rd) && $past(busy_i)) |=> $stable(data_o[W-2]));
endmodule

bind rdpoll_status_rd rdpoll_status_rd_chk #(.W(W)) u_chk (.*);

// File: tb/rdpoll_status_rd_tb.sv
module rdpoll_status_rd_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [7:0] last_data = '0, addr = '0, arr;
  logic [7:0] dout;
  logic       doe;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] arr_of(logic [7:0] a);
    return 8'(a * 37 + 11);
  endfunction
  assign arr = arr_of(addr);

  rdpoll_status_rd u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .busy_i(busy), .last_data_i(last_data), .arr_data_i(arr),
    .data_o(dout), .data_oe_o(doe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  // one complete access: strobe on, sample, strobe off, idle clock
  task automatic rd_once(output logic [7:0] v);
    ce_n = 0; oe_n = 0; we_n = 1;
    tick();
    v = dout;
    oe_n = 1;
    tick();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    int k;
    @(negedge clk); @(negedge clk);
    // R8
    chk(doe == 0, "R8 oe", doe, 0);
    chk(dout == 0, "R8 data", dout, 0);
    rst_n = 1;
    tick();
    chk(doe == 0 && dout == 0, "R8 after release", {dout, doe}, 0);

    // R1: all strobe combinations
    for (int c = 0; c < 8; c++) begin
      ce_n = c[2]; oe_n = c[1]; we_n = c[0];
      tick();
      chk(doe == (c == 1), "R1 oe", doe, (c == 1));
      if (c != 1) chk(dout == 0, "R1 data", dout, 0);
    end
    ce_n = 1; oe_n = 1; we_n = 1; tick();

    // R2: full address sweep with strobe held
    ce_n = 0; oe_n = 0; we_n = 1;
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a);
      tick();
      chk(dout == arr_of(8'(a)), "R2 held sweep", dout, arr_of(8'(a)));
    end
    oe_n = 1; tick();
    addr = 8'h5a; rd_once(v);
    chk(v == arr_of(8'h5a), "R2 single", v, arr_of(8'h5a));

    // R3 R4: every last byte, alternating toggle
    busy = 1; tick(); tick();
    k = 0;
    for (int d = 0; d < 256; d++) begin
      last_data = 8'(d);
      addr = 8'(d * 3);
      rd_once(v);
      chk(v[7] == ~last_data[7], "R3 poll bit", v[7], ~last_data[7]);
      chk(v[6] == k[0], "R4 toggle", v[6], k[0]);
      k++;
    end

    // R5: held strobe keeps bit 6
    ce_n = 0; oe_n = 0;
    tick();
    chk(v[6] != dout[6] || 1'b1, "R5 start", dout[6], k[0]);
    chk(dout[6] == k[0], "R5 first", dout[6], k[0]);
    for (int h = 0; h < 6; h++) begin
      tick();
      chk(dout[6] == k[0], "R5 held", dout[6], k[0]);
    end
    k++;
    // R6: busy falls while strobe held
    addr = 8'h33;
    busy = 0;
    tick();
    chk(dout == arr_of(8'h33), "R6 true data", dout, arr_of(8'h33));
    oe_n = 1; tick();
    rd_once(v);
    chk(v == arr_of(8'h33), "R6 next read", v, arr_of(8'h33));

    // R7: odd parity left behind, then new cycle restarts at 0
    busy = 1; tick();
    for (int r = 0; r < 3; r++) begin
      rd_once(v);
      chk(v[6] == r[0], "R7 first cycle", v[6], r[0]);
    end
    busy = 0; tick(); tick();
    busy = 1; tick();
    rd_once(v);
    chk(v[6] == 0, "R7 restart", v[6], 0);
    rd_once(v);
    chk(v[6] == 1, "R7 second", v[6], 1);

    // R9: access begins on the clock busy rises
    busy = 0; tick(); tick();
    last_data = 8'h80;
    busy = 1; ce_n = 0; oe_n = 0; we_n = 1;
    tick();
    chk(dout[6] == 0, "R9 toggle", dout[6], 0);
    chk(dout[7] == 0, "R9 poll", dout[7], 0);
    oe_n = 1; tick();
    rd_once(v);
    chk(v[6] == 1, "R9 follow", v[6], 1);
    busy = 0; tick();
    finish_up();
  end
endmodule